// File: doc/BRIEF.md
# Audio Master and Bit Clock Divider

This block derives the two clocks an audio serial port needs, a master clock for an external converter and a bit clock for the serial data lines, from one of two source clocks chosen by a select input. Each output has its own 6-bit divide setting. A setting of N above zero divides the source by 2N with an even duty cycle. A setting of zero routes the selected source straight to that output.

Software-facing logic gives the block a one-cycle start strobe and a one-cycle stop strobe. The master clock has its own mode input, so a design that does not need the master clock can keep it low while the bit clock runs. The block also gives the serializer a tick: a one-source-cycle pulse at each rising edge of the bit clock, so the serializer can run in the source domain with no second clock.

All state sits in the selected source domain and advances by counting source edges. The source select and the mode input are meant to change only while the block is stopped. Glitch-free switching between sources is not provided.

Top module: `audclk_gen`

## Requirements
- R1: With a bit-clock divide value N in 1..63, bit_clk has a period of 2N source cycles and is high for N of them. After the source edge that captures start_pulse, bit_clk first rises N source edges later.
- R2: mst_clk follows the same rule with its own divide value, independent of the bit-clock setting, whenever mclk_mode is 1.
- R3: A divide value of 0 makes that output equal to the selected source clock while the block is running, and bit_tick is then high on every source cycle.
- R4: src_sel = 0 selects clk_periph and src_sel = 1 selects clk_alt. Every count in R1 and R2 is taken on edges of the selected clock.
- R5: While mclk_mode is 0, mst_clk stays low and bit_clk keeps running.
- R6: After the source edge that captures stop_pulse, mst_clk, bit_clk and bit_tick are all low. If start_pulse and stop_pulse are captured on the same edge, stop wins.
- R7: A new divide value written while the block runs takes effect at the next rising edge of that output. The half-period already in progress, and the falling edge that ends it, still use the old value.
- R8: For N >= 1, bit_tick is high for exactly one source cycle: the first source cycle in which bit_clk is high after each rising edge.
- R9: After reset, with no start strobe, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_periph | input | 1 | Source clock selected when src_sel = 0 |
| clk_alt | input | 1 | Source clock selected when src_sel = 1 |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 1 | Source clock select |
| mst_div | input | 6 | Master clock divide value (0 = pass-through) |
| bit_div | input | 6 | Bit clock divide value (0 = pass-through) |
| mclk_mode | input | 1 | 1 = drive the master clock, 0 = hold it low |
| start_pulse | input | 1 | One-cycle strobe that starts both outputs |
| stop_pulse | input | 1 | One-cycle strobe that stops both outputs |
| mst_clk | output | 1 | Master clock |
| bit_clk | output | 1 | Bit clock |
| bit_tick | output | 1 | One-cycle pulse in the source domain at each bit clock rising edge |

## Verification
A wrong count or a wrong held divide value shows at bit_clk and mst_clk as an edge in the wrong source cycle. It is visible within one output period, at most 126 source cycles. A wrong run flag shows at once as an output that still toggles, or a tick that still pulses, in the first cycle after a stop. A divide value loaded at the wrong moment moves the first edge after a mid-run change, so the bench samples every source cycle across that change.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
   localparam int NCH     = 2;
   localparam int CH_MST  = 0;
   localparam int CH_BIT  = 1;
   typedef enum logic {SRC_PERIPH = 1'b0, SRC_ALT = 1'b1} src_sel_e;
endpackage

// File: rtl/audclk_srcmux.sv
module audclk_srcmux (
   input  logic clk_a,
   input  logic clk_b,
   input  logic sel,
   output logic clk_o
);
   always_comb clk_o = (sel == audclk_pkg::SRC_ALT) ? clk_b : clk_a;
endmodule

// File: rtl/audclk_ctrl.sv
module audclk_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_pulse,
   input  logic stop_pulse,
   output logic run
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           run <= 1'b0;
      else if (stop_pulse)  run <= 1'b0;
      else if (start_pulse) run <= 1'b1;
   end
endmodule

// File: rtl/audclk_divider.sv
module audclk_divider #(
   parameter int DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             clk_o,
   output logic             tick_o,
   output logic             q_o,
   output logic [DIV_W-1:0] act_o
);
   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] act;
   logic             q;
   logic             tick_q;
   logic             pass;

   assign pass = (act == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         act    <= '0;
         q      <= 1'b0;
         tick_q <= 1'b0;
      end else if (!en || pass) begin
         cnt    <= '0;
         act    <= div;
         q      <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= 1'b0;
         if (cnt == act - DIV_W'(1)) begin
            cnt <= '0;
            q   <= ~q;
            if (!q) begin
               tick_q <= 1'b1;
               act    <= div;
            end
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end
   end

   always_comb begin
      clk_o  = en & (pass ? clk : q);
      tick_o = en & (pass ? 1'b1 : tick_q);
   end

   assign q_o   = q;
   assign act_o = act;
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen #(
   parameter int DIV_W = 6
) (
   input  logic             clk_periph,
   input  logic             clk_alt,
   input  logic             rst_n,
   input  logic             src_sel,
   input  logic [DIV_W-1:0] mst_div,
   input  logic [DIV_W-1:0] bit_div,
   input  logic             mclk_mode,
   input  logic             start_pulse,
   input  logic             stop_pulse,
   output logic             mst_clk,
   output logic             bit_clk,
   output logic             bit_tick
);
   import audclk_pkg::*;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16)
         else $error("audclk_gen: DIV_W must lie in 1..16");
   end

   logic                        src_clk;
   logic                        run;
   logic [NCH-1:0]              ch_en;
   logic [NCH-1:0][DIV_W-1:0]   ch_div;
   logic [NCH-1:0]              ch_clk;
   logic [NCH-1:0]              ch_tick;
   logic [NCH-1:0]              ch_q;
   logic [NCH-1:0][DIV_W-1:0]   ch_act;

   audclk_srcmux u_mux (
      .clk_a (clk_periph),
      .clk_b (clk_alt),
      .sel   (src_sel),
      .clk_o (src_clk)
   );

   audclk_ctrl u_ctrl (
      .clk         (src_clk),
      .rst_n       (rst_n),
      .start_pulse (start_pulse),
      .stop_pulse  (stop_pulse),
      .run         (run)
   );

   always_comb begin
      ch_en[CH_MST]  = run & mclk_mode;
      ch_en[CH_BIT]  = run;
      ch_div[CH_MST] = mst_div;
      ch_div[CH_BIT] = bit_div;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      audclk_divider #(.DIV_W(DIV_W)) u_div (
         .clk    (src_clk),
         .rst_n  (rst_n),
         .en     (ch_en[i]),
         .div    (ch_div[i]),
         .clk_o  (ch_clk[i]),
         .tick_o (ch_tick[i]),
         .q_o    (ch_q[i]),
         .act_o  (ch_act[i])
      );
   end

   assign mst_clk  = ch_clk[CH_MST];
   assign bit_clk  = ch_clk[CH_BIT];
   assign bit_tick = ch_tick[CH_BIT];
endmodule

// File: rtl/audclk_gen_chk.sv
module audclk_gen_chk #(
   parameter int DIV_W = 6
) (
   input logic                      src_clk,
   input logic                      rst_n,
   input logic                      run,
   input logic                      mclk_mode,
   input logic                      mst_clk,
   input logic                      bit_clk,
   input logic                      bit_tick,
   input logic [1:0]                ch_en,
   input logic [1:0]                ch_q,
   input logic [1:0][DIV_W-1:0]     ch_act
);
   // R6: stopped block drives nothing
   p_idle_quiet_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
      !run |-> (!bit_tick && !bit_clk && !mst_clk))
      else $error("p_idle_quiet_r6");

   // R5: master toggle cleared while its mode is off
   p_mst_gated_r5: assert property (@(posedge src_clk) disable iff (!rst_n)
      !mclk_mode |=> !ch_q[0])
      else $error("p_mst_gated_r5");

   // R7: held divide value changes only at a rising edge
   p_div_hold_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
      (ch_en[1] && $past(ch_en[1]) && ($past(ch_act[1]) != '0) && !$rose(ch_q[1]))
      |-> $stable(ch_act[1]))
      else $error("p_div_hold_r7");

   // R8: tick lasts one cycle in divided mode
   p_tick_single_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
      (bit_tick && ch_act[1] != '0) |=> !bit_tick)
      else $error("p_tick_single_r8");

   // R8: tick only while the divided bit clock is high
   p_tick_high_r8: assert property (@(posedge src_clk) disable iff (!rst_n)
      (bit_tick && ch_act[1] != '0) |-> ch_q[1])
      else $error("p_tick_high_r8");
endmodule

bind audclk_gen audclk_gen_chk #(.DIV_W(DIV_W)) u_chk (
   .src_clk   (src_clk),
   .rst_n     (rst_n),
   .run       (run),
   .mclk_mode (mclk_mode),
   .mst_clk   (mst_clk),
   .bit_clk   (bit_clk),
   .bit_tick  (bit_tick),
   .ch_en     (ch_en),
   .ch_q      (ch_q),
   .ch_act    (ch_act)
);

// File: tb/audclk_gen_test.sv
`timescale 1ns/1ps
module audclk_gen_test;
   localparam int CLK_PERIOD = 10;
   localparam int ALT_PERIOD = 14;

   logic       clk_periph = 1'b0;
   logic       clk_alt    = 1'b0;
   logic       rst_n      = 1'b0;
   logic       src_sel    = 1'b0;
   logic [5:0] mst_div    = 6'd1;
   logic [5:0] bit_div    = 6'd1;
   logic       mclk_mode  = 1'b0;
   logic       start_pulse = 1'b0;
   logic       stop_pulse  = 1'b0;
   logic       mst_clk, bit_clk, bit_tick;

   int n_checks = 0;
   int n_fail   = 0;
   int wd_cnt   = 0;

   always #(CLK_PERIOD/2) clk_periph = ~clk_periph;
   always #(ALT_PERIOD/2) clk_alt    = ~clk_alt;

   audclk_gen uut (
      .clk_periph (clk_periph), .clk_alt (clk_alt), .rst_n (rst_n),
      .src_sel (src_sel), .mst_div (mst_div), .bit_div (bit_div),
      .mclk_mode (mclk_mode), .start_pulse (start_pulse),
      .stop_pulse (stop_pulse), .mst_clk (mst_clk), .bit_clk (bit_clk),
      .bit_tick (bit_tick)
   );

   task automatic report();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk_periph) begin
      wd_cnt++;
      if (wd_cnt > 100000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual=expired expected=done");
         report();
      end
   end

   task automatic check(string req, logic act, logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   // wait for the next selected-source edge, sample 1 ns later (source high)
   task automatic step();
      if (src_sel) @(posedge clk_alt); else @(posedge clk_periph);
      #1;
   endtask

   task automatic low_phase();
      if (src_sel) #(ALT_PERIOD/2); else #(CLK_PERIOD/2);
   endtask

   task automatic start();
      start_pulse = 1'b1; step(); start_pulse = 1'b0;
   endtask

   task automatic stop_and_check(string req);
      stop_pulse = 1'b1; step(); stop_pulse = 1'b0;
      for (int k = 0; k < 3; k++) begin
         check({req, " stop bit_clk"}, bit_clk, 1'b0);
         check({req, " stop mst_clk"}, mst_clk, 1'b0);
         check({req, " stop bit_tick"}, bit_tick, 1'b0);
         step();
      end
   endtask

   // R9: reset state
   task automatic t_reset();
      for (int k = 0; k < 4; k++) begin
         step();
         check("R9 bit_clk", bit_clk, 1'b0);
         check("R9 mst_clk", mst_clk, 1'b0);
         check("R9 bit_tick", bit_tick, 1'b0);
      end
   endtask

   // R1, R2, R4, R5, R8: divided outputs sampled every source cycle
   task automatic t_run(string req, int nm, int nb, logic sel, logic mmode);
      src_sel = sel; mst_div = 6'(nm); bit_div = 6'(nb); mclk_mode = mmode;
      step();
      start();
      for (int k = 1; k <= 4 * (nm > nb ? nm : nb); k++) begin
         step();
         check({req, " bit_clk"}, bit_clk, 1'(((k / nb) % 2) == 1));
         check({req, " R8 bit_tick"}, bit_tick, 1'((k % (2 * nb)) == nb));
         check({req, " mst_clk"}, mst_clk, mmode ? 1'(((k / nm) % 2) == 1) : 1'b0);
      end
      stop_and_check({req, " R6"});
   endtask

   // R3: divide value zero passes the source through
   task automatic t_pass();
      src_sel = 1'b0; mst_div = 6'd0; bit_div = 6'd0; mclk_mode = 1'b1;
      step();
      start();
      for (int k = 0; k < 4; k++) begin
         step();
         check("R3 bit_clk high", bit_clk, 1'b1);
         check("R3 mst_clk high", mst_clk, 1'b1);
         check("R3 bit_tick", bit_tick, 1'b1);
         low_phase();
         check("R3 bit_clk low", bit_clk, 1'b0);
         check("R3 mst_clk low", mst_clk, 1'b0);
      end
      stop_and_check("R3 R6");
   endtask

   // R7: mid-run divide change waits for the next rising edge
   task automatic t_change();
      src_sel = 1'b0; bit_div = 6'd2; mst_div = 6'd1; mclk_mode = 1'b0;
      step();
      start();
      for (int k = 1; k <= 3; k++) begin
         step();
         check("R7 before change", bit_clk, 1'(((k / 2) % 2) == 1));
      end
      bit_div = 6'd4;
      for (int k = 4; k <= 15; k++) begin
         step();
         check("R7 after change", bit_clk, (k < 6) ? 1'b0 : 1'((((k - 6) / 4) % 2) == 0));
         check("R7 R8 tick", bit_tick, 1'(k == 6 || k == 14));
      end
      stop_and_check("R7 R6");
   endtask

   // R6: stop wins over a simultaneous start
   task automatic t_both();
      src_sel = 1'b0; bit_div = 6'd1; mclk_mode = 1'b1; mst_div = 6'd1;
      step();
      start();
      step(); step();
      start_pulse = 1'b1; stop_pulse = 1'b1; step();
      start_pulse = 1'b0; stop_pulse = 1'b0;
      for (int k = 0; k < 4; k++) begin
         check("R6 both bit_clk", bit_clk, 1'b0);
         check("R6 both bit_tick", bit_tick, 1'b0);
         check("R6 both mst_clk", mst_clk, 1'b0);
         step();
      end
   endtask

   initial begin
      #(3 * CLK_PERIOD + 2);
      rst_n = 1'b1;
      t_reset();
      t_run("R1 n=1", 1, 1, 1'b0, 1'b0);
      t_run("R1 n=3", 2, 3, 1'b0, 1'b0);
      t_run("R2 m=3 b=2", 3, 2, 1'b0, 1'b1);
      t_run("R2 m=1 b=5", 1, 5, 1'b0, 1'b1);
      t_run("R4 alt m=2 b=3", 2, 3, 1'b1, 1'b1);
      t_run("R5 mode off", 2, 2, 1'b0, 1'b0);
      t_pass();
      t_change();
      t_both();
      report();
   end
endmodule